// File: doc/BRIEF.md
# Hot-Plug Slot Status and Event Register Bank

This block is the register bank of a bus hot-plug controller. Each slot has one 32-bit word. The word holds the slot's power/enable state and its two indicator settings, which software writes. It also shows the live condition of the slot's sensors: power fault, attention button, retention latch and the two presence pins. A change on any sensor is caught in a sticky event bit. Each event bit has its own interrupt mask.

A controller-level word holds a global interrupt mask, a global error mask, a command-complete mask and an arbiter-error mask. It also holds two sticky status bits, set by pulses from the command engine and from the bus arbiter. A read-only locator word shows which sources are pending. Bit 0 is the command-complete source and bit i+1 is slot i. The single interrupt line is the OR of the locator, blocked while the global interrupt mask is set.

The raw sensor inputs are asynchronous to the clock and pass through a synchronizer before they are used. Register access is word addressed:
- address 0 is the controller word;
- address 1 is the locator;
- address 2+i is slot i.

Reads are combinational from the current address.

Top module: `hp_slot_regs`

## Requirements
- R1: After reset every slot word reads `0x7F000C7F` when the sensors are idle (state 3 = disabled, both indicators 3 = off, all seven mask bits [30:24] set, no events). The controller word reads `0x0000000F`, the locator reads 0 and `irq_o` is 0.
- R2: Slot bits [5:0] are read/write: [1:0] state (1 powered only, 2 enabled, 3 disabled, 0 reserved), [3:2] power indicator and [5:4] attention indicator (1 on, 2 blink, 3 off).
- R3: A slot word shows the sensors after a two-flop synchronizer: bit 6 power fault active low, bit 7 button, bit 8 latch, bits [11:10] presence (3 = empty). A raw change first shows in the read after the second clock edge.
- R4: Each event bit sets on either edge of its synchronized source, one edge after the live bit changes. The sources are: bit 16 presence, bit 17 isolated power fault (bit 6 input), bit 18 button, bit 19 latch, bit 20 connected power fault input.
- R5: Writing 1 to an event bit clears it. Writing 0 leaves it set.
- R6: Slot bits 31, 23:21, 15:12 and 9 read zero and writes to them have no effect.
- R7: Slot mask bit 24+k blocks event bit 16+k from the locator. Bits 29 and 30 (error-path masks for latch change and connected fault) are stored but do not affect the locator.
- R8: Locator bit 0 is set while command-complete status is set and its mask (controller bit 2) is 0. Bit i+1 is set while slot i has an unmasked event. The locator ignores writes.
- R9: Controller bits [3:0] are read/write masks. Bit 16 is set by a `cmd_done_i` pulse and bit 17 by an `arb_err_i` pulse. Both clear when 1 is written to them. All other bits read zero.
- R10: `irq_o` is 1 exactly when the locator is non-zero and controller bit 0 (global interrupt mask) is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | ADDR_W (3) | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data of the addressed word |
| cmd_done_i | input | 1 | Command-complete pulse |
| arb_err_i | input | 1 | Arbiter-error pulse |
| fault_n_raw | input | NUM_SLOTS | Raw power-fault inputs, low = fault |
| button_raw | input | NUM_SLOTS | Raw attention-button inputs |
| latch_raw | input | NUM_SLOTS | Raw retention-latch sensor inputs |
| presence_raw | input | 2*NUM_SLOTS | Raw presence pins, two per slot |
| conn_fault_raw | input | NUM_SLOTS | Raw connected power-fault inputs |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the pipeline between a raw sensor change, its live status bit and its event bit, which lag each other by one clock.

The stimulus changes an input just after a clock edge. It then reads the word on three successive cycles and expects no change, then the live bit alone, then both.

The interrupt path is stepped through each mask on its own, and through the error-path masks that must not matter. A locator entry is held pending while the global mask toggles.

// File: rtl/hp_slot_pkg.sv
package hp_slot_pkg;

   localparam int WORD_W  = 32;
   localparam int CTL_W   = 6;     // state + two indicators
   localparam int N_EV    = 5;     // latched events per slot
   localparam int N_MSK   = 7;     // five interrupt masks + two error masks
   localparam int EV_LSB  = 16;
   localparam int MSK_LSB = 24;
   localparam int N_RAW   = 6;     // fault_n, button, latch, presence[1:0], conn fault

   typedef enum logic [1:0] {
      ST_RSVD     = 2'd0,
      ST_PWR_ONLY = 2'd1,
      ST_ENABLED  = 2'd2,
      ST_DISABLED = 2'd3
   } slot_state_e;

   typedef enum logic [1:0] {
      IND_RSVD  = 2'd0,
      IND_ON    = 2'd1,
      IND_BLINK = 2'd2,
      IND_OFF   = 2'd3
   } indicator_e;

   // idle level of the raw vector {conn, presence[1:0], latch, button, fault_n}
   localparam logic [N_RAW-1:0] RAW_IDLE = 6'b0_11_0_0_1;

   // controller word bit positions
   localparam int C_GINT_MSK = 0;
   localparam int C_CMD_MSK  = 2;
   localparam int C_CMD_DET  = 16;
   localparam int C_ARB_DET  = 17;

endpackage

// File: rtl/hp_sync.sv
module hp_sync #(
   parameter int                WIDTH   = 1,
   parameter int                STAGES  = 2,
   parameter logic [WIDTH-1:0]  RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   if (STAGES < 2) begin : g_bad_stages
      $error("hp_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < STAGES; s++) chain[s] <= RST_VAL;
      end else begin
         chain[0] <= d;
         for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];

endmodule

// File: rtl/hp_slot_unit.sv
module hp_slot_unit
   import hp_slot_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr,
   input  logic [CTL_W-1:0]   w_ctl,
   input  logic [N_EV-1:0]    w_clr,
   input  logic [N_MSK-1:0]   w_msk,
   input  logic [N_RAW-1:0]   raw,
   output logic [WORD_W-1:0]  word,
   output logic               pend
);

   logic [N_RAW-1:0] live, prev;
   logic [N_EV-1:0]  edges, ev_q;
   logic [CTL_W-1:0] ctl_q;
   logic [N_MSK-1:0] msk_q;

   hp_sync #(.WIDTH(N_RAW), .STAGES(SYNC_STAGES), .RST_VAL(RAW_IDLE)) sync_i (
      .clk(clk), .rst_n(rst_n), .d(raw), .q(live)
   );

   // raw index: 0 fault_n, 1 button, 2 latch, 4:3 presence, 5 conn fault
   always_comb begin
      edges[0] = live[4:3] != prev[4:3];
      edges[1] = live[0] ^ prev[0];
      edges[2] = live[1] ^ prev[1];
      edges[3] = live[2] ^ prev[2];
      edges[4] = live[5] ^ prev[5];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev  <= RAW_IDLE;
         ev_q  <= '0;
         ctl_q <= {IND_OFF, IND_OFF, ST_DISABLED};
         msk_q <= '1;
      end else begin
         prev <= live;
         // a new edge in the clearing cycle is kept
         ev_q <= (ev_q & ~(wr ? w_clr : '0)) | edges;
         if (wr) begin
            ctl_q <= w_ctl;
            msk_q <= w_msk;
         end
      end
   end

   assign word = {1'b0, msk_q, 3'b000, ev_q, 4'b0000, live[4:3],
                  1'b0, live[2], live[1], live[0], ctl_q};
   assign pend = |(ev_q & ~msk_q[N_EV-1:0]);

endmodule

// File: rtl/hp_ctl_unit.sv
module hp_ctl_unit
   import hp_slot_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [3:0]        w_msk,
   input  logic [1:0]        w_clr,
   input  logic              cmd_done,
   input  logic              arb_err,
   output logic [WORD_W-1:0] word,
   output logic              gint_masked,
   output logic              cmd_pend
);

   logic [3:0] msk_q;
   logic       cmd_q, arb_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         msk_q <= '1;
         cmd_q <= 1'b0;
         arb_q <= 1'b0;
      end else begin
         if (wr) msk_q <= w_msk;
         cmd_q <= (cmd_q & ~(wr & w_clr[0])) | cmd_done;
         arb_q <= (arb_q & ~(wr & w_clr[1])) | arb_err;
      end
   end

   assign word        = {14'd0, arb_q, cmd_q, 12'd0, msk_q};
   assign gint_masked = msk_q[C_GINT_MSK];
   assign cmd_pend    = cmd_q & ~msk_q[C_CMD_MSK];

endmodule

// File: rtl/hp_slot_regs.sv
module hp_slot_regs
   import hp_slot_pkg::*;
#(
   parameter int NUM_SLOTS   = 4,
   parameter int SYNC_STAGES = 2,
   localparam int ADDR_W     = $clog2(NUM_SLOTS + 2)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr_en,
   input  logic [ADDR_W-1:0]      addr,
   input  logic [31:0]            wdata,
   output logic [31:0]            rdata,
   input  logic                   cmd_done_i,
   input  logic                   arb_err_i,
   input  logic [NUM_SLOTS-1:0]   fault_n_raw,
   input  logic [NUM_SLOTS-1:0]   button_raw,
   input  logic [NUM_SLOTS-1:0]   latch_raw,
   input  logic [2*NUM_SLOTS-1:0] presence_raw,
   input  logic [NUM_SLOTS-1:0]   conn_fault_raw,
   output logic                   irq_o
);

   localparam int LOC_USED = NUM_SLOTS + 1;

   if (NUM_SLOTS < 1 || NUM_SLOTS > 31) begin : g_bad_slots
      $error("hp_slot_regs: NUM_SLOTS must be 1..31");
   end

   logic [WORD_W-1:0]           ctl_word, loc_word;
   logic [WORD_W*NUM_SLOTS-1:0] slot_flat;
   logic [NUM_SLOTS-1:0]        slot_pend;
   logic                        gint_masked, cmd_pend;

   hp_ctl_unit ctl_i (
      .clk(clk), .rst_n(rst_n),
      .wr(wr_en && addr == ADDR_W'(0)),
      .w_msk(wdata[3:0]),
      .w_clr(wdata[C_ARB_DET:C_CMD_DET]),
      .cmd_done(cmd_done_i), .arb_err(arb_err_i),
      .word(ctl_word), .gint_masked(gint_masked), .cmd_pend(cmd_pend)
   );

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
      hp_slot_unit #(.SYNC_STAGES(SYNC_STAGES)) slot_i (
         .clk(clk), .rst_n(rst_n),
         .wr(wr_en && addr == ADDR_W'(i + 2)),
         .w_ctl(wdata[CTL_W-1:0]),
         .w_clr(wdata[EV_LSB+N_EV-1:EV_LSB]),
         .w_msk(wdata[MSK_LSB+N_MSK-1:MSK_LSB]),
         .raw({conn_fault_raw[i], presence_raw[2*i+1], presence_raw[2*i],
               latch_raw[i], button_raw[i], fault_n_raw[i]}),
         .word(slot_flat[WORD_W*i +: WORD_W]),
         .pend(slot_pend[i])
      );
   end

   if (LOC_USED < WORD_W) begin : g_loc_pad
      assign loc_word = {{(WORD_W-LOC_USED){1'b0}}, slot_pend, cmd_pend};
   end else begin : g_loc_full
      assign loc_word = {slot_pend, cmd_pend};
   end

   assign irq_o = (|loc_word) & ~gint_masked;

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(0)) rdata = ctl_word;
      if (addr == ADDR_W'(1)) rdata = loc_word;
      for (int i = 0; i < NUM_SLOTS; i++)
         if (addr == ADDR_W'(i + 2)) rdata = slot_flat[WORD_W*i +: WORD_W];
   end

endmodule

// File: rtl/hp_slot_regs_chk.sv
module hp_slot_regs_chk #(
   parameter int NUM_SLOTS = 4
) (
   input logic                    clk,
   input logic                    rst_n,
   input logic                    irq_o,
   input logic                    cmd_done_i,
   input logic [31:0]             ctl_word,
   input logic [31:0]             loc_word,
   input logic [32*NUM_SLOTS-1:0] slot_flat
);

   // R10
   irq_gmask_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_word[0] |-> !irq_o);

   // R10
   irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> loc_word != 32'd0);

   // R9
   ctl_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_word[31:18] == 14'd0 && ctl_word[15:4] == 12'd0);

   // R9
   cmd_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_done_i |=> ctl_word[16]);

   // R8
   loc_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      loc_word[0] |-> (ctl_word[16] && !ctl_word[2]));

   // R8
   loc_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (loc_word >> (NUM_SLOTS + 1)) == 32'd0);

   for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot_chk
      // R6
      slot_rsvd_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (slot_flat[32*i +: 32] & 32'h80E0_F200) == 32'd0);

      // R7
      loc_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
         loc_word[i+1] |-> (slot_flat[32*i+16 +: 5] != 5'd0));
   end

endmodule

bind hp_slot_regs hp_slot_regs_chk #(.NUM_SLOTS(NUM_SLOTS)) chk_i (
   .clk(clk), .rst_n(rst_n), .irq_o(irq_o), .cmd_done_i(cmd_done_i),
   .ctl_word(ctl_word), .loc_word(loc_word), .slot_flat(slot_flat)
);

// File: tb/hp_slot_regs_tb_top.sv
`timescale 1ns/1ps
module hp_slot_regs_tb_top;

   localparam int N = 4;
   localparam int AW = $clog2(N + 2);

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           wr_en = 1'b0;
   logic [AW-1:0]  addr = '0;
   logic [31:0]    wdata = '0;
   logic [31:0]    rdata;
   logic           cmd_done_i = 1'b0, arb_err_i = 1'b0;
   logic [N-1:0]   fault_n_raw = '1, button_raw = '0, latch_raw = '0, conn_fault_raw = '0;
   logic [2*N-1:0] presence_raw = '1;
   logic           irq_o;

   int n_chk = 0, n_fail = 0;
   bit done = 1'b0;

   typedef struct { string req; int sel; logic [31:0] val; } exp_t;
   exp_t expq[$];

   always #4 clk = ~clk;

   hp_slot_regs #(.NUM_SLOTS(N)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .cmd_done_i(cmd_done_i), .arb_err_i(arb_err_i),
      .fault_n_raw(fault_n_raw), .button_raw(button_raw), .latch_raw(latch_raw),
      .presence_raw(presence_raw), .conn_fault_raw(conn_fault_raw), .irq_o(irq_o)
   );

   // monitor: pops one expected item per falling edge
   always @(negedge clk) begin
      if (expq.size() > 0) begin
         exp_t it;
         logic [31:0] act;
         it  = expq.pop_front();
         act = (it.sel < 0) ? {31'd0, irq_o} : rdata;
         n_chk++;
         if (act !== it.val) begin
            n_fail++;
            $display("FAIL %s sel=%0d actual=%08h expected=%08h", it.req, it.sel, act, it.val);
         end
      end
   end

   task automatic chk(input int a, input logic [31:0] v, input string r);
      @(posedge clk); #1;
      addr = AW'(a);
      expq.push_back('{r, a, v});
      wait (expq.size() == 0);
   endtask

   task automatic chk_irq(input logic v, input string r);
      @(posedge clk); #1;
      expq.push_back('{r, -1, {31'd0, v}});
      wait (expq.size() == 0);
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(posedge clk); #1;
      addr = AW'(a); wdata = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
   endtask

   initial begin
      idle(3);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk(2, 32'h7F00_0C7F, "R1");
      chk(5, 32'h7F00_0C7F, "R1");
      chk(0, 32'h0000_000F, "R1");
      chk(1, 32'h0000_0000, "R1");
      chk_irq(1'b0, "R1");
      // R2 control fields
      wr(3, 32'h7F00_0026);
      chk(3, 32'h7F00_0C66, "R2");
      wr(2, 32'h0000_0000);
      chk(2, 32'h0000_0C40, "R2");
      // R6 reserved bits
      wr(2, 32'h80E0_F200);
      chk(2, 32'h0000_0C40, "R6");
      wr(2, 32'hFFFF_FFFF);
      chk(2, 32'h7F00_0C7F, "R6");
      // R3 synchronizer latency, then R4 event one cycle later
      @(posedge clk); #1 button_raw[3] = 1'b1;
      chk(5, 32'h7F00_0C7F, "R3");
      chk(5, 32'h7F00_0CFF, "R3");
      chk(5, 32'h7F04_0CFF, "R4");
      // R5 clear, then R4 falling edge
      wr(5, 32'h7F04_003F);
      chk(5, 32'h7F00_0CFF, "R5");
      @(posedge clk); #1 button_raw[3] = 1'b0;
      idle(5);
      chk(5, 32'h7F04_0C7F, "R4");
      // R3 several live bits on slot 2
      @(posedge clk); #1;
      fault_n_raw[2] = 1'b0; button_raw[2] = 1'b1; latch_raw[2] = 1'b1;
      presence_raw[5:4] = 2'b01;
      idle(5);
      chk(4, 32'h7F0F_05BF, "R3");
      // R5 zero keeps, one clears
      wr(4, 32'h7F00_003F);
      chk(4, 32'h7F0F_05BF, "R5");
      wr(4, 32'h7F05_003F);
      chk(4, 32'h7F0A_05BF, "R5");
      // R4 connected fault on slot 1
      @(posedge clk); #1 conn_fault_raw[1] = 1'b1;
      idle(5);
      chk(3, 32'h7F10_0C66, "R4");
      // R7 masking into locator
      chk(1, 32'h0, "R7");
      wr(0, 32'h0);
      chk(0, 32'h0, "R9");
      chk_irq(1'b0, "R7");
      wr(4, 32'h7700_003F);
      chk(1, 32'h8, "R7");
      chk_irq(1'b1, "R10");
      wr(4, 32'h1F00_003F);
      chk(1, 32'h0, "R7");
      chk(4, 32'h1F0A_05BF, "R7");
      wr(4, 32'h7700_003F);
      // R10 global mask
      wr(0, 32'h1);
      chk(1, 32'h8, "R8");
      chk_irq(1'b0, "R10");
      wr(0, 32'h0);
      chk_irq(1'b1, "R10");
      // R8 locator ignores writes
      wr(1, 32'hFFFF_FFFF);
      chk(1, 32'h8, "R8");
      // R9 status pulses
      @(posedge clk); #1 cmd_done_i = 1'b1;
      @(posedge clk); #1 cmd_done_i = 1'b0;
      chk(0, 32'h0001_0000, "R9");
      chk(1, 32'h9, "R8");
      @(posedge clk); #1 arb_err_i = 1'b1;
      @(posedge clk); #1 arb_err_i = 1'b0;
      chk(0, 32'h0003_0000, "R9");
      wr(0, 32'h0001_0000);
      chk(0, 32'h0002_0000, "R9");
      chk(1, 32'h8, "R8");
      wr(0, 32'hFFFF_FFFF);
      chk(0, 32'h0000_000F, "R9");
      chk_irq(1'b0, "R10");
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule